// File: doc/BRIEF.md
# Split/Cascadable Interval Timer Pair

This block holds two interval timers, A and B, programmed over a byte-wide register bus. Each timer takes its count tick from one of several sources: a prescaler of the system clock (divide by 512, 256, 64 or 8), the undivided system clock, a sub-clock input, or an external clock pin. The two asynchronous inputs are synchronized and edge-detected. A timer counts ticks up from zero. When the counter equals the timer's data register on a tick, the counter returns to zero and the timer's pending flag is set. The interrupt output is the pending flag gated by the interrupt enable.

One mode bit in timer A's control register joins the two counters into a single 16-bit timer. In that mode timer B's data register supplies the upper compare byte, timer A's control register governs everything, and timer B's own control fields have no effect. Software clears a pending flag by writing 0 to it. Writing 1 to the flag does nothing. A hardware set in the same cycle as a software clear wins.

Top module: `split_interval_timer`

## Requirements
- R1: After reset, all four registers read 0x00 and both interrupt outputs are low. This means two 8-bit timers, divide-by-512 source, counting disabled and interrupts disabled.
- R2: The register addresses are 0 = control A, 1 = control B, 2 = data A and 3 = data B. The control fields are bit 7 = join mode, bits 6:4 = source, bit 3 = counter clear, bit 2 = count enable, bit 1 = interrupt enable and bit 0 = pending. Bit 3 always reads 0. Bit 0 reads the pending flag. The data registers read back what was written.
- R3: Counting starts from 0 and advances by one per tick. A tick that finds the counter equal to the data value returns the counter to 0 and sets pending, so one interval lasts data+1 ticks.
- R4: Source code 000 ticks every 512 system clocks, 001 every 256, 010 every 64, 011 every 8, and 100 every clock.
- R5: Source code 101 gives one tick per rising edge of the sub-clock input, and code 110 gives one tick per rising edge of the external clock pin. Each input passes through a two-flop synchronizer first. The input that is not selected has no effect.
- R6: Source code 111 produces no ticks.
- R7: The counter advances only while bit 2 is set.
- R8: Writing 1 to bit 3 returns that timer's counter to 0. Writing 0 to bit 3 leaves the counter unchanged.
- R9: Writing 0 to bit 0 clears pending and writing 1 to bit 0 leaves it unchanged. A hardware set in the same cycle as a clearing write leaves pending set.
- R10: An interrupt output is high exactly when its timer's interrupt enable and pending flag are both set.
- R11: With bit 7 of control A set, the counters form one 16-bit counter, A low and B high. It is compared with {data B, data A}, so the interval is that value + 1 ticks. It sets timer A's pending flag.
- R12: In join mode, timer B's clear, enable and interrupt bits have no effect, timer B's pending flag is not set, and the B interrupt output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_clk_i | input | 1 | Asynchronous sub-clock input |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| irq_a_o | output | 1 | Timer A interrupt |
| irq_b_o | output | 1 | Timer B interrupt |

## Verification
The collision rule for the pending flag is the hardest case to reach from the ports. A clearing write has to arrive in the very edge where the counter hits its match. The stimulus makes this certain by using data 0 on the undivided clock, so every cycle is a match, and then writing 0 to the pending bit. The 16-bit interval is checked to the exact clock. A write to timer B's clear bit is placed in the middle of the interval, and the match edge must not move. Prescaler rates are measured as the edge count between a clearing write and the next set, which does not depend on the prescaler's phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    SRC_D512 = 3'd0,
    SRC_D256 = 3'd1,
    SRC_D64  = 3'd2,
    SRC_D8   = 3'd3,
    SRC_SYS  = 3'd4,
    SRC_SUB  = 3'd5,
    SRC_EXT  = 3'd6,
    SRC_OFF  = 3'd7
  } tmr_src_e;

  typedef struct packed {
    logic     wide;
    tmr_src_e src;
    logic     en;
    logic     ie;
  } tmr_ctrl_t;

  localparam int unsigned TMR_N_TAPS = 4;
  // power-of-two exponents of the prescaler taps, indexed by source code 0..3
  localparam int unsigned TMR_DIV_EXP [TMR_N_TAPS] = '{9, 8, 6, 3};

  localparam logic [1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [1:0] ADDR_CTRL_B = 2'd1;
  localparam logic [1:0] ADDR_DATA_A = 2'd2;
  localparam logic [1:0] ADDR_DATA_B = 2'd3;

  function automatic logic pick_tick(input tmr_src_e s,
                                     input logic [TMR_N_TAPS-1:0] taps,
                                     input logic sub_p,
                                     input logic ext_p);
    logic t;
    case (s)
      SRC_D512, SRC_D256, SRC_D64, SRC_D8: t = taps[s[1:0]];
      SRC_SYS: t = 1'b1;
      SRC_SUB: t = sub_p;
      SRC_EXT: t = ext_p;
      default: t = 1'b0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PRE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [TMR_N_TAPS-1:0] tap_o
);

  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // a tap fires on the last state of its low-order bit group
  for (genvar i = 0; i < TMR_N_TAPS; i++) begin : g_tap
    localparam int unsigned E = TMR_DIV_EXP[i];
    assign tap_o[i] = &cnt_q[E-1:0];
  end

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic pulse_o
);

  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q, prev_d;

  always_comb begin
    sh_d   = {sh_q[STAGES-2:0], async_i};
    prev_d = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  assign pulse_o = sh_q[STAGES-1] & ~prev_q;

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/split_interval_timer.sv
module split_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_clk_i,
  input  logic              ext_clk_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_a_o,
  output logic              irq_b_o
);

  localparam int unsigned N_CH   = 2;
  localparam int unsigned WIDE_W = N_CH * DATA_W;
  localparam int unsigned PRE_W  = TMR_DIV_EXP[0];

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // tick sources
  logic [TMR_N_TAPS-1:0] taps;
  logic [1:0]            async_in, async_pulse;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n_i), .tap_o(taps)
  );

  assign async_in = {ext_clk_i, sub_clk_i};

  for (genvar s = 0; s < 2; s++) begin : g_sync
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n_i), .async_i(async_in[s]), .pulse_o(async_pulse[s])
    );
  end

  // register state
  tmr_ctrl_t   ctrl_q [N_CH];
  tmr_ctrl_t   ctrl_d [N_CH];
  logic [DATA_W-1:0] data_q [N_CH];
  logic [DATA_W-1:0] data_d [N_CH];
  logic [N_CH-1:0]   pend_q, pend_d;

  logic [N_CH-1:0]   wr_ctrl, wr_data, tick, step, hit, sw_clr, clr, inc;
  logic [DATA_W-1:0] cnt [N_CH];
  logic [N_CH-1:0]   match8;
  logic              joined, match16;

  assign joined  = ctrl_q[0].wide;
  assign match16 = ({cnt[1], cnt[0]} == {data_q[1], data_q[0]});

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign wr_ctrl[i] = reg_wr_i && (reg_addr_i == (ADDR_CTRL_A + 2'(i)));
    assign wr_data[i] = reg_wr_i && (reg_addr_i == (ADDR_DATA_A + 2'(i)));
    assign tick[i]    = pick_tick(ctrl_q[i].src, taps, async_pulse[0], async_pulse[1]);
    assign match8[i]  = (cnt[i] == data_q[i]);
  end

  // counting control
  always_comb begin
    step[0]   = tick[0] & ctrl_q[0].en;
    step[1]   = ~joined & tick[1] & ctrl_q[1].en;
    hit[0]    = step[0] & (joined ? match16 : match8[0]);
    hit[1]    = step[1] & match8[1];
    sw_clr[0] = wr_ctrl[0] & reg_wdata_i[3];
    sw_clr[1] = wr_ctrl[1] & reg_wdata_i[3] & ~joined;
    clr[0]    = sw_clr[0] | hit[0];
    inc[0]    = step[0] & ~hit[0];
    if (joined) begin
      clr[1] = clr[0];
      inc[1] = inc[0] & (&cnt[0]);
    end else begin
      clr[1] = sw_clr[1] | hit[1];
      inc[1] = step[1] & ~hit[1];
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_cnt
    tmr_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n_i), .clr_i(clr[i]), .inc_i(inc[i]), .cnt_o(cnt[i])
    );
  end

  // register next state
  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      ctrl_d[i] = ctrl_q[i];
      data_d[i] = data_q[i];
      if (wr_ctrl[i]) begin
        ctrl_d[i].wide = reg_wdata_i[7];
        ctrl_d[i].src  = tmr_src_e'(reg_wdata_i[6:4]);
        ctrl_d[i].en   = reg_wdata_i[2];
        ctrl_d[i].ie   = reg_wdata_i[1];
      end
      if (wr_data[i]) data_d[i] = reg_wdata_i;
      // hardware set outranks a clearing write
      pend_d[i] = hit[i] | (pend_q[i] & ~(wr_ctrl[i] & ~reg_wdata_i[0]));
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < N_CH; i++) begin
        ctrl_q[i] <= '0;
        data_q[i] <= '0;
      end
      pend_q <= '0;
    end else begin
      for (int i = 0; i < N_CH; i++) begin
        ctrl_q[i] <= ctrl_d[i];
        data_q[i] <= data_d[i];
      end
      pend_q <= pend_d;
    end
  end

  // read path
  always_comb begin
    case (reg_addr_i)
      ADDR_CTRL_A: reg_rdata_o = {ctrl_q[0].wide, ctrl_q[0].src, 1'b0,
                                  ctrl_q[0].en, ctrl_q[0].ie, pend_q[0]};
      ADDR_CTRL_B: reg_rdata_o = {ctrl_q[1].wide, ctrl_q[1].src, 1'b0,
                                  ctrl_q[1].en, ctrl_q[1].ie, pend_q[1]};
      ADDR_DATA_A: reg_rdata_o = data_q[0];
      default:     reg_rdata_o = data_q[1];
    endcase
  end

  assign irq_a_o = ctrl_q[0].ie & pend_q[0];
  assign irq_b_o = ~joined & ctrl_q[1].ie & pend_q[1];

  // R9
  pend_wr1_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_ctrl[0] && reg_wdata_i[0] && pend_q[0]) |=> pend_q[0]);

  // R9
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_ctrl[0] && !reg_wdata_i[0] && !hit[0]) |=> !pend_q[0]);

  // R6
  src_off_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ctrl_q[0].src == SRC_OFF && !sw_clr[0]) |=> $stable(cnt[0]));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (hit[0] && !joined) |=> (cnt[0] == '0 && pend_q[0]));

  // R12
  wide_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (joined && !pend_q[1]) |=> !pend_q[1]);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(irq_a_o) |-> pend_q[0]);

endmodule

// File: tb/sim_split_interval_timer.sv
module sim_split_interval_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  split_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .sub_clk_i(sub_clk), .ext_clk_i(ext_clk),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_a_o(irq_a), .irq_b_o(irq_b)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse_sub();
    sub_clk = 1'b1; repeat (4) @(negedge clk);
    sub_clk = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic pulse_ext();
    ext_clk = 1'b1; repeat (4) @(negedge clk);
    ext_clk = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rreg(2'(a), v);
      check("R1 register reset", v, 0);
    end
    check("R1 irq_a reset", irq_a, 0);
    check("R1 irq_b reset", irq_b, 0);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wreg(2'd0, 8'h7F);
    rreg(2'd0, v);
    check("R2 ctrl readback, bit3 zero", v, 8'h76);
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'hA5);
    wreg(2'd3, 8'h3C);
    rreg(2'd2, v); check("R2 data A readback", v, 8'hA5);
    rreg(2'd3, v); check("R2 data B readback", v, 8'h3C);
  endtask

  task automatic t_interval();
    logic [7:0] v;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd4);
    wreg(2'd0, 8'h4E);
    repeat (4) @(negedge clk);
    check("R3 no set before data+1 ticks", irq_a, 0);
    @(negedge clk);
    check("R3 set at data+1 ticks", irq_a, 1);
    rreg(2'd0, v);
    check("R3 ctrl shows pending", v, 8'h47);
  endtask

  task automatic t_prescale(input logic [2:0] sel, input int n);
    int cnt = 0;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd0);
    wreg(2'd0, {1'b0, sel, 4'hE});
    for (int k = 0; k < 700; k++) begin
      if (irq_a) break;
      @(negedge clk);
    end
    wreg(2'd0, {1'b0, sel, 4'h6});
    for (int k = 0; k < 700; k++) begin
      if (irq_a) break;
      cnt++;
      @(negedge clk);
    end
    check($sformatf("R4 tick spacing sel=%0d", sel), cnt, n - 1);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd0);
    wreg(2'd0, 8'h4E);
    @(negedge clk);
    check("R9 set every tick", irq_a, 1);
    wreg(2'd0, 8'h46);
    check("R9 hardware set wins over clear", irq_a, 1);
    wreg(2'd0, 8'h43);
    wreg(2'd0, 8'h43);
    rreg(2'd0, v);
    check("R9 write 1 leaves pending", v[0], 1);
    wreg(2'd0, 8'h42);
    rreg(2'd0, v);
    check("R9 write 0 clears pending", v[0], 0);
    check("R10 irq drops with pending", irq_a, 0);
  endtask

  task automatic t_irq_gate();
    logic [7:0] v;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd0);
    wreg(2'd0, 8'h4C);
    @(negedge clk);
    check("R10 irq low with ie clear", irq_a, 0);
    rreg(2'd0, v);
    check("R10 pending still set", v, 8'h45);
  endtask

  task automatic t_ext();
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd2);
    wreg(2'd0, 8'h6E);
    repeat (3) pulse_sub();
    check("R5 sub-clock ignored on ext source", irq_a, 0);
    repeat (2) pulse_ext();
    check("R5 ext two edges", irq_a, 0);
    pulse_ext();
    check("R5 ext third edge sets", irq_a, 1);
  endtask

  task automatic t_sub();
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd2);
    wreg(2'd0, 8'h5E);
    repeat (3) pulse_ext();
    check("R5 ext ignored on sub source", irq_a, 0);
    repeat (3) pulse_sub();
    check("R5 sub third edge sets", irq_a, 1);
  endtask

  task automatic t_off();
    logic [7:0] v;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd0);
    wreg(2'd0, 8'h7E);
    repeat (2) pulse_ext();
    repeat (2) pulse_sub();
    repeat (20) @(negedge clk);
    rreg(2'd0, v);
    check("R6 source 111 never counts", v[0], 0);
  endtask

  task automatic t_enable();
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd0);
    wreg(2'd0, 8'h4A);
    repeat (20) @(negedge clk);
    check("R7 no count while disabled", irq_a, 0);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'd3);
    wreg(2'd0, 8'h6E);
    repeat (3) pulse_ext();
    wreg(2'd0, 8'h6E);
    rreg(2'd0, v);
    check("R8 clear bit reads 0", v, 8'h66);
    repeat (3) pulse_ext();
    check("R8 counter restarted", irq_a, 0);
    pulse_ext();
    check("R8 full interval after clear", irq_a, 1);
  endtask

  task automatic t_split_b();
    wreg(2'd0, 8'h00);
    wreg(2'd1, 8'h00);
    wreg(2'd3, 8'd4);
    wreg(2'd1, 8'h4E);
    repeat (4) @(negedge clk);
    check("R3 B no set early", irq_b, 0);
    @(negedge clk);
    check("R3 B set at data+1", irq_b, 1);
    check("R3 A unaffected by B", irq_a, 0);
  endtask

  task automatic t_wide();
    logic [7:0] v;
    wreg(2'd0, 8'h80);
    wreg(2'd1, 8'h4E);
    wreg(2'd2, 8'h02);
    wreg(2'd3, 8'h01);
    wreg(2'd0, 8'hCE);
    repeat (100) @(negedge clk);
    wreg(2'd1, 8'h4E);
    repeat (157) @(negedge clk);
    check("R12 B clear ignored, no early set", irq_a, 0);
    @(negedge clk);
    check("R11 16-bit interval 259 ticks", irq_a, 1);
    check("R12 irq_b low in join mode", irq_b, 0);
    rreg(2'd1, v);
    check("R12 B pending not set", v[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_interval();
    t_prescale(3'd3, 8);
    t_prescale(3'd2, 64);
    t_prescale(3'd1, 256);
    t_prescale(3'd0, 512);
    t_collide();
    t_irq_gate();
    t_ext();
    t_sub();
    t_off();
    t_enable();
    t_clear();
    t_split_b();
    t_wide();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule